// File: doc/BRIEF.md
# CAN Adapter Host Glue: Interrupt Gate and Window Decode

This block sits between a host register bus and a byte-wide CAN controller on an adapter card. The host reaches it through three register windows, each with its own select line. The bridge window holds one 32-bit interrupt control and status word. The controller window passes byte accesses through to the controller's register port. The small identification window returns a fixed version byte.

The controller raises a level-sensitive interrupt. An enable bit in the control word gates that level onto a registered, active-high host interrupt line. Writing the enable bit takes effect on the next clock edge, whether or not an interrupt is pending. The status bit in the same word always shows the raw controller level. Read data comes back combinationally in the same cycle as the read strobe. Writes take effect at the next rising clock edge. A block reset also holds the controller in reset.

Top module: `can_glue_top`

## Requirements
- R1: While `rst` is sampled high, the control word clears to 0 and `host_irq` is 0. `cc_rst` is 1 in the cycle after each edge that samples `rst` high, and 0 in the cycle after each edge that samples it low.
- R2: A bridge write at byte offset 0x38 stores all 32 data bits. A later read at 0x38 returns the stored value in every bit except bit 23.
- R3: A read of bridge offset 0x38 returns the present `cc_irq` level in bit 23. This holds whatever was written to bit 23 and whatever the enable bit is.
- R4: After each clock edge, `host_irq` equals the enable bit (bit 13 of the control word) ANDed with `cc_irq`, both as they stood at that edge.
- R5: If a write at 0x38 changes bit 13, `host_irq` follows the new bit 13 at the next edge. A pending interrupt appears or disappears at once. With no interrupt pending, the line stays 0.
- R6: Bridge offsets other than 0x38 read as 0. Writes to them leave the control word unchanged.
- R7: Controller-window offsets 0x00 to 0x1F drive `cc_wr` or `cc_rd` for that access. `cc_addr` carries the low 5 offset bits and `cc_wdata` carries data bits 7:0. A read returns `cc_rdata` in bits 7:0, with the upper bits 0.
- R8: Controller-window offsets 0x20 to 0x7F drive neither `cc_wr` nor `cc_rd`. Reads there return 0, and writes change no controller register, including the one with the same low 5 bits.
- R9: In the identification window, offset 7 reads 0xD0 (version 13 in bits 7:4, 0 in bits 3:0). The other offsets read 0, and writes there have no effect.
- R10: `host_rdata` is 0 whenever no window is selected or `host_rd` is low. At most one select is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brg_sel | input | 1 | Selects the bridge window (control/status word) |
| ctl_sel | input | 1 | Selects the controller pass-through window |
| ver_sel | input | 1 | Selects the identification window |
| host_addr | input | 7 | Byte offset within the selected window |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data |
| cc_rst | output | 1 | Registered hardware reset to the CAN controller |
| cc_addr | output | 5 | Controller register offset |
| cc_wr | output | 1 | Controller write strobe |
| cc_rd | output | 1 | Controller read strobe |
| cc_wdata | output | 8 | Controller write data |
| cc_rdata | input | 8 | Controller read data |
| cc_irq | input | 1 | Level interrupt from the controller |
| host_irq | output | 1 | Registered, gated host interrupt |

## Verification
On every cycle, the assertions check four things. The interrupt line follows the stored enable and the live controller level. A write of the enable bit moves the line on the next edge. The control word holds without a write, and status bit 23 always mirrors `cc_irq`. They also check that out-of-range controller offsets raise no strobe and that the version byte appears only at offset 7.

Only the bench's scenarios can show the rest. One is that stored bits read back exactly. Another is that a dropped write at an aliasing offset leaves the controller register intact. A third is that enable toggles behave correctly both while an interrupt is pending and while none is. The bench's cycle model of the interrupt line is compared on every clock.

// File: rtl/can_glue_pkg.sv
package can_glue_pkg;
  // byte offset of the interrupt control/status word in the bridge window
  localparam int unsigned CSR_OFS  = 'h38;
  // bit positions inside the control/status word
  localparam int unsigned IEN_BIT  = 13;
  localparam int unsigned IST_BIT  = 23;
  // offset of the version byte in the identification window
  localparam int unsigned VER_OFS  = 7;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/cg_bridge_csr.sv
module cg_bridge_csr
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cc_irq,
  output logic [DATA_W-1:0] rdata,
  output logic              host_irq
);
  logic [DATA_W-1:0] csr_q;
  logic              irq_q;
  logic              hit, csr_wr, en_nxt;

  assign hit    = sel && (addr == ADDR_W'(CSR_OFS));
  assign csr_wr = hit && wr;
  // enable seen by the gate: a write this cycle takes effect immediately
  assign en_nxt = csr_wr ? wdata[IEN_BIT] : csr_q[IEN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (csr_wr) csr_q <= wdata;
      irq_q <= en_nxt & cc_irq;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit && rd) begin
      rdata          = csr_q;
      rdata[IST_BIT] = cc_irq;
    end
  end

  assign host_irq = irq_q;

  // R4
  irq_gate_on_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_q[IEN_BIT] && cc_irq && !csr_wr) |=> host_irq);
  // R4
  irq_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!csr_q[IEN_BIT] && !csr_wr) |=> !host_irq);
  // R5
  en_write_on_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && wdata[IEN_BIT] && cc_irq) |=> host_irq);
  // R5
  en_write_off_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !wdata[IEN_BIT]) |=> !host_irq);
  // R6
  csr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_wr |=> $stable(csr_q));
  // R3
  status_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && rd) |-> (rdata[IST_BIT] == cc_irq));
endmodule

// File: rtl/cg_ctrl_pass.sv
module cg_ctrl_pass
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CC_SPAN = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [$clog2(CC_SPAN)-1:0] cc_addr,
  output logic                      cc_wr,
  output logic                      cc_rd,
  output logic [BYTE_W-1:0]         cc_wdata,
  input  logic [BYTE_W-1:0]         cc_rdata
);
  localparam int unsigned CC_AW = $clog2(CC_SPAN);

  logic in_rng;

  assign in_rng   = (addr < ADDR_W'(CC_SPAN));
  assign cc_addr  = addr[CC_AW-1:0];
  assign cc_wdata = wdata;
  assign cc_wr    = sel && wr && in_rng;
  assign cc_rd    = sel && rd && in_rng;
  assign rdata    = cc_rd ? {{(DATA_W-BYTE_W){1'b0}}, cc_rdata} : '0;

  // R8
  drop_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && (addr >= ADDR_W'(CC_SPAN))) |-> (!cc_wr && !cc_rd && rdata == '0));
  // R7
  fwd_read_chk: assert property (@(posedge clk) disable iff (rst)
    cc_rd |-> (rdata[BYTE_W-1:0] == cc_rdata && rdata[DATA_W-1:BYTE_W] == '0));
endmodule

// File: rtl/cg_ver_win.sv
module cg_ver_win
  import can_glue_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned VER_AW  = 3,
  parameter int unsigned VER_NUM = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rd,
  input  logic [VER_AW-1:0] addr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [BYTE_W-1:0] VER_BYTE = BYTE_W'(VER_NUM << 4);

  assign rdata = (sel && rd && addr == VER_AW'(VER_OFS)) ?
                 {{(DATA_W-BYTE_W){1'b0}}, VER_BYTE} : '0;

  // R9
  ver_only_at_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata != '0) |-> (sel && rd && addr == VER_AW'(VER_OFS)));
endmodule

// File: rtl/can_glue_top.sv
module can_glue_top
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CC_SPAN = 32,
  parameter int unsigned VER_AW  = 3,
  parameter int unsigned VER_NUM = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       brg_sel,
  input  logic                       ctl_sel,
  input  logic                       ver_sel,
  input  logic [ADDR_W-1:0]          host_addr,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       cc_rst,
  output logic [$clog2(CC_SPAN)-1:0] cc_addr,
  output logic                       cc_wr,
  output logic                       cc_rd,
  output logic [7:0]                 cc_wdata,
  input  logic [7:0]                 cc_rdata,
  input  logic                       cc_irq,
  output logic                       host_irq
);
  logic [DATA_W-1:0] brg_rdata, ctl_rdata, ver_rdata;
  logic              cc_rst_q;

  cg_bridge_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_brg (
    .clk(clk), .rst(rst), .sel(brg_sel), .addr(host_addr),
    .wr(host_wr), .rd(host_rd), .wdata(host_wdata), .cc_irq(cc_irq),
    .rdata(brg_rdata), .host_irq(host_irq)
  );

  cg_ctrl_pass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CC_SPAN(CC_SPAN)) u_ctl (
    .clk(clk), .rst(rst), .sel(ctl_sel), .addr(host_addr),
    .wr(host_wr), .rd(host_rd), .wdata(host_wdata[BYTE_W-1:0]),
    .rdata(ctl_rdata), .cc_addr(cc_addr), .cc_wr(cc_wr), .cc_rd(cc_rd),
    .cc_wdata(cc_wdata), .cc_rdata(cc_rdata)
  );

  cg_ver_win #(.DATA_W(DATA_W), .VER_AW(VER_AW), .VER_NUM(VER_NUM)) u_ver (
    .clk(clk), .rst(rst), .sel(ver_sel), .rd(host_rd),
    .addr(host_addr[VER_AW-1:0]), .rdata(ver_rdata)
  );

  // each window returns zero when not addressed, so an OR merges them
  assign host_rdata = brg_rdata | ctl_rdata | ver_rdata;

  always_ff @(posedge clk) begin
    cc_rst_q <= rst;
  end
  assign cc_rst = cc_rst_q;

  // R1
  ctrl_reset_chk: assert property (@(posedge clk) rst |=> cc_rst);
  // R1
  ctrl_release_chk: assert property (@(posedge clk) !rst |=> !cc_rst);
  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({brg_sel, ctl_sel, ver_sel}));
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_rd || !(brg_sel || ctl_sel || ver_sel)) |-> (host_rdata == '0));
endmodule

// File: tb/can_glue_top_tb_top.sv
module can_glue_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        brg_sel, ctl_sel, ver_sel;
  logic [6:0]  host_addr;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata, host_rdata;
  logic        cc_rst;
  logic [4:0]  cc_addr;
  logic        cc_wr, cc_rd;
  logic [7:0]  cc_wdata, cc_rdata;
  logic        cc_irq;
  logic        host_irq;

  always #5 clk = ~clk;

  can_glue_top dut_i (
    .clk(clk), .rst(rst), .brg_sel(brg_sel), .ctl_sel(ctl_sel), .ver_sel(ver_sel),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cc_rst(cc_rst),
    .cc_addr(cc_addr), .cc_wr(cc_wr), .cc_rd(cc_rd), .cc_wdata(cc_wdata),
    .cc_rdata(cc_rdata), .cc_irq(cc_irq), .host_irq(host_irq)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // controller responder: 32 byte registers, combinational read
  logic [7:0] cc_mem [32];
  int         cc_wr_count = 0;
  assign cc_rdata = cc_rd ? cc_mem[cc_addr] : 8'h00;
  always @(posedge clk) begin
    if (cc_wr) begin
      cc_mem[cc_addr] <= cc_wdata;
      cc_wr_count++;
    end
  end

  // reference model of the control word and interrupt line
  logic [31:0] m_csr;
  logic        m_irq;
  bit          started = 0;
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_csr = 32'h0;
      m_irq = 1'b0;
    end else begin
      if (brg_sel && host_wr && host_addr == 7'h38) m_csr = host_wdata;
      m_irq = m_csr[13] & cc_irq;
    end
  end
  always @(negedge clk) begin
    if (started) chk("R4 per-cycle host_irq", {31'h0, host_irq}, {31'h0, m_irq});
  end

  // captured controller strobes of the last access
  logic       cap_wr, cap_rd;
  logic [4:0] cap_addr;

  task automatic acc(input logic [2:0] sel, input logic [6:0] a, input logic w,
                     input logic r, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    {brg_sel, ctl_sel, ver_sel} = sel;
    host_addr = a; host_wr = w; host_rd = r; host_wdata = d;
    #1;
    q = host_rdata; cap_wr = cc_wr; cap_rd = cc_rd; cap_addr = cc_addr;
    @(posedge clk);
    #1;
    {brg_sel, ctl_sel, ver_sel} = 3'b000;
    host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
  endtask

  localparam logic [2:0] BRG = 3'b100, CTL = 3'b010, VER = 3'b001;

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    int          wc;
    for (int i = 0; i < 32; i++) cc_mem[i] = 8'h00;
    rst = 1; cc_irq = 0;
    {brg_sel, ctl_sel, ver_sel} = 3'b000;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cc_rst during reset", {31'h0, cc_rst}, 32'h1);
    chk("R1 host_irq during reset", {31'h0, host_irq}, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R1 cc_rst released", {31'h0, cc_rst}, 32'h0);
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R1 control word after reset", q, 32'h0);

    // R3: status shows raw level while disabled
    @(negedge clk); cc_irq = 1;
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R3 status bit with enable off", q, 32'h0080_0000);
    chk("R4 line stays low while disabled", {31'h0, host_irq}, 32'h0);
    @(negedge clk); cc_irq = 0;

    // R2: stored value, bit 23 replaced by level
    acc(BRG, 7'h38, 1, 0, 32'hA5A5_5A5A, q);
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R2 read back with irq low", q, 32'hA525_5A5A);
    @(negedge clk); cc_irq = 1;
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R3 read back with irq high", q, 32'hA5A5_5A5A);
    @(negedge clk); cc_irq = 0;

    // R4: enable then follow the level
    acc(BRG, 7'h38, 1, 0, 32'h0000_2000, q);
    @(negedge clk); cc_irq = 1;
    @(negedge clk);
    chk("R4 line follows level up", {31'h0, host_irq}, 32'h1);
    cc_irq = 0;
    @(negedge clk);
    chk("R4 line follows level down", {31'h0, host_irq}, 32'h0);

    // R5: toggle enable while pending
    cc_irq = 1;
    @(negedge clk);
    acc(BRG, 7'h38, 1, 0, 32'h0, q);
    chk("R5 disable while pending", {31'h0, host_irq}, 32'h0);
    acc(BRG, 7'h38, 1, 0, 32'h0000_2000, q);
    chk("R5 enable while pending", {31'h0, host_irq}, 32'h1);
    // R5: toggle while idle
    @(negedge clk); cc_irq = 0;
    acc(BRG, 7'h38, 1, 0, 32'h0, q);
    acc(BRG, 7'h38, 1, 0, 32'h0000_2000, q);
    chk("R5 enable while idle", {31'h0, host_irq}, 32'h0);

    // R6: other bridge offsets
    acc(BRG, 7'h3C, 1, 0, 32'hFFFF_FFFF, q);
    acc(BRG, 7'h00, 1, 0, 32'hFFFF_FFFF, q);
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R6 word unchanged by other offsets", q, 32'h0000_2000);
    acc(BRG, 7'h3C, 0, 1, 0, q);
    chk("R6 other offset reads zero", q, 32'h0);

    // R7: forwarded accesses
    acc(CTL, 7'h05, 1, 0, 32'hFFFF_FF3C, q);
    chk("R7 write strobe forwarded", {31'h0, cap_wr}, 32'h1);
    chk("R7 controller offset", {27'h0, cap_addr}, 32'h5);
    acc(CTL, 7'h05, 0, 1, 0, q);
    chk("R7 read back byte", q, 32'h0000_003C);
    acc(CTL, 7'h1F, 1, 0, 32'h77, q);
    acc(CTL, 7'h1F, 0, 1, 0, q);
    chk("R7 top forwarded offset", q, 32'h0000_0077);

    // R8: high offsets dropped
    wc = cc_wr_count;
    acc(CTL, 7'h25, 1, 0, 32'h99, q);
    chk("R8 no write strobe", {31'h0, cap_wr}, 32'h0);
    chk("R8 controller write count", wc, cc_wr_count);
    acc(CTL, 7'h25, 0, 1, 0, q);
    chk("R8 no read strobe", {31'h0, cap_rd}, 32'h0);
    chk("R8 high read zero", q, 32'h0);
    acc(CTL, 7'h05, 0, 1, 0, q);
    chk("R8 aliased register intact", q, 32'h0000_003C);

    // R9: identification window
    acc(VER, 7'h07, 0, 1, 0, q);
    chk("R9 version byte", q, 32'h0000_00D0);
    acc(VER, 7'h03, 0, 1, 0, q);
    chk("R9 other offset zero", q, 32'h0);
    acc(VER, 7'h07, 1, 0, 32'hFF, q);
    acc(VER, 7'h07, 0, 1, 0, q);
    chk("R9 write ignored", q, 32'h0000_00D0);

    // R10: no read strobe or no select
    acc(BRG, 7'h38, 0, 0, 0, q);
    chk("R10 no read strobe", q, 32'h0);
    acc(3'b000, 7'h38, 0, 1, 0, q);
    chk("R10 no select", q, 32'h0);

    // R1: reset again clears the word and the line
    @(negedge clk); cc_irq = 1; rst = 1;
    @(negedge clk);
    chk("R1 cc_rst on second reset", {31'h0, cc_rst}, 32'h1);
    rst = 0;
    acc(BRG, 7'h38, 0, 1, 0, q);
    chk("R1 word cleared, status live", q, 32'h0080_0000);
    chk("R1 line low after reset", {31'h0, host_irq}, 32'h0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule